// File: doc/BRIEF.md
# Paged Program Memory Window Translator

This block lets a CPU with a 16-bit address space reach up to 1 MB of program memory. One fixed 16 KB slice of the CPU map, addresses 0x8000 to 0xBFFF, works as a movable window. A 6-bit page number selects which of 64 physical 16 KB pages shows through that window. Every CPU address is turned into a 20-bit physical address. A flag marks whether the address landed inside the window.

The page number can be loaded in two ways. The first is an ordinary bus write to a parameterised register address, which changes the translation one cycle late. The second is a side-band port that call and return-from-call sequences use to load or read the page without a bus cycle. A load on the side-band port shows up right after the clock edge that takes it, so the next fetch already uses the new page. Bus reads of the register address return the page that is in force at that moment.

Top module: `page_window_xlate`

## Requirements
- R1: After reset the page number is 0, so sideRdData is 0 and a bus read of the register returns 0x00.
- R2: For cpuAddr in 0x8000..0xBFFF, inWindow is 1 and physAddr equals {page[5:0], cpuAddr[13:0]}.
- R3: For cpuAddr outside 0x8000..0xBFFF, inWindow is 0 and physAddr is cpuAddr with four zero bits in front.
- R4: A bus write (busWrEn high, cpuAddr equal to REG_ADDR) taken at clock edge N leaves the page unchanged after edge N and applies it after edge N+1.
- R5: A bus write to any address other than REG_ADDR leaves the page unchanged.
- R6: A side-band write (sideWrEn high) taken at edge N sets the page to sideWrData directly after edge N.
- R7: When a bus write and a side-band write are taken at the same edge, the side-band value is kept and the bus value is discarded for good.
- R8: A side-band write taken at the edge where a pending bus write would apply wins, and the pending bus value is dropped.
- R9: With busRdEn high and cpuAddr equal to REG_ADDR, busRdHit is 1 and busRdData is {2'b00, page}. Otherwise busRdHit is 0 and busRdData is 0x00. This includes a page loaded through the side-band port.
- R10: Bits 7:6 of busWrData are ignored, so the page becomes busWrData[5:0] and reads back with zero upper bits.
- R11: sideRdData always shows the page currently in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuAddr | input | 16 | CPU address |
| busWrEn | input | 1 | Bus write strobe |
| busRdEn | input | 1 | Bus read strobe |
| busWrData | input | 8 | Bus write data |
| busRdData | output | 8 | Register read data, zero when not selected |
| busRdHit | output | 1 | Bus read targets the page register |
| sideWrEn | input | 1 | Side-band page load strobe |
| sideWrData | input | 6 | Side-band page value |
| sideRdData | output | 6 | Current page, side-band read |
| physAddr | output | 20 | Translated physical address |
| inWindow | output | 1 | Address lies in the paged window |

## Verification
The checker verifies on every cycle the translation rules inside and outside the window and the zero upper read bits. It also checks that a side-band load is visible one edge later and that an accepted bus write without competition lands exactly one edge after it is taken. Several cases can only be shown by the bench's directed scenarios: the bus value being discarded in a collision, a pending write being cancelled by a later side-band load, writes to foreign addresses being ignored, and the reset value being read back through the bus.

// File: rtl/pwx_pkg.sv
package pwx_pkg;
  localparam int CPU_W  = 16;
  localparam int PIX_W  = 6;
  localparam int OFF_W  = 14;
  localparam int REG_W  = 8;
  localparam int PHYS_W = PIX_W + OFF_W;
  localparam int SEL_W  = CPU_W - OFF_W;

  typedef struct packed {
    logic             load;
    logic [PIX_W-1:0] loadVal;
    logic             rdHit;
  } pwxStrobe_t;
endpackage

// File: rtl/pwx_ctrl.sv
module pwx_ctrl
  import pwx_pkg::*;
#(
  parameter logic [CPU_W-1:0] REG_ADDR = 16'h0030
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CPU_W-1:0] cpuAddr,
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic [REG_W-1:0] busWrData,
  input  logic             sideWrEn,
  input  logic [PIX_W-1:0] sideWrData,
  output pwxStrobe_t       strobes
);
  logic             regSel;
  logic             busHit;
  logic             pendValid;
  logic [PIX_W-1:0] pendData;
  logic             unusedHiBits;

  assign regSel       = (cpuAddr == REG_ADDR);
  assign busHit       = busWrEn & regSel;
  assign unusedHiBits = ^busWrData[REG_W-1:PIX_W];

  // A bus write waits one stage. A side-band write at the same edge cancels it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendData  <= '0;
    end else begin
      pendValid <= busHit & ~sideWrEn;
      if (busHit) pendData <= busWrData[PIX_W-1:0];
    end
  end

  // The side-band port has priority over a pending bus value.
  always_comb begin
    strobes.rdHit = busRdEn & regSel;
    if (sideWrEn) begin
      strobes.load    = 1'b1;
      strobes.loadVal = sideWrData;
    end else begin
      strobes.load    = pendValid;
      strobes.loadVal = pendData;
    end
  end
endmodule

// File: rtl/pwx_datapath.sv
module pwx_datapath
  import pwx_pkg::*;
#(
  parameter logic [SEL_W-1:0] WIN_SEL = 2'b10
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwxStrobe_t        strobes,
  input  logic [CPU_W-1:0]  cpuAddr,
  output logic [PHYS_W-1:0] physAddr,
  output logic              inWindow,
  output logic [REG_W-1:0]  busRdData,
  output logic [PIX_W-1:0]  pageNow
);
  logic [PIX_W-1:0] pageReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pageReg <= '0;
    else if (strobes.load) pageReg <= strobes.loadVal;
  end

  assign pageNow  = pageReg;
  assign inWindow = (cpuAddr[CPU_W-1:OFF_W] == WIN_SEL);

  generate
    if (PHYS_W > CPU_W) begin : g_wide
      always_comb begin
        if (inWindow) physAddr = {pageReg, cpuAddr[OFF_W-1:0]};
        else          physAddr = {{(PHYS_W-CPU_W){1'b0}}, cpuAddr};
      end
    end else begin : g_narrow
      always_comb begin
        if (inWindow) physAddr = {pageReg, cpuAddr[OFF_W-1:0]};
        else          physAddr = cpuAddr[PHYS_W-1:0];
      end
    end
  endgenerate

  assign busRdData = strobes.rdHit ? {{(REG_W-PIX_W){1'b0}}, pageReg} : '0;
endmodule

// File: rtl/page_window_xlate.sv
module page_window_xlate
  import pwx_pkg::*;
#(
  parameter logic [CPU_W-1:0] REG_ADDR = 16'h0030,
  parameter logic [SEL_W-1:0] WIN_SEL  = 2'b10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CPU_W-1:0]  cpuAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [REG_W-1:0]  busWrData,
  output logic [REG_W-1:0]  busRdData,
  output logic              busRdHit,
  input  logic              sideWrEn,
  input  logic [PIX_W-1:0]  sideWrData,
  output logic [PIX_W-1:0]  sideRdData,
  output logic [PHYS_W-1:0] physAddr,
  output logic              inWindow
);
  pwxStrobe_t strobes;

  pwx_ctrl #(.REG_ADDR(REG_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .sideWrEn(sideWrEn),
    .sideWrData(sideWrData), .strobes(strobes)
  );

  pwx_datapath #(.WIN_SEL(WIN_SEL)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cpuAddr(cpuAddr),
    .physAddr(physAddr), .inWindow(inWindow), .busRdData(busRdData),
    .pageNow(sideRdData)
  );

  assign busRdHit = strobes.rdHit;
endmodule

// File: rtl/pwx_checker.sv
module pwx_checker
  import pwx_pkg::*;
#(
  parameter logic [CPU_W-1:0] REG_ADDR = 16'h0030
) (
  input logic              clk,
  input logic              rstN,
  input logic [CPU_W-1:0]  cpuAddr,
  input logic              busWrEn,
  input logic [REG_W-1:0]  busWrData,
  input logic [REG_W-1:0]  busRdData,
  input logic              busRdHit,
  input logic              sideWrEn,
  input logic [PIX_W-1:0]  sideWrData,
  input logic [PIX_W-1:0]  sideRdData,
  input logic [PHYS_W-1:0] physAddr,
  input logic              inWindow
);
  logic             prevHit;
  logic [PIX_W-1:0] prevData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevHit  <= 1'b0;
      prevData <= '0;
    end else begin
      prevHit  <= busWrEn && (cpuAddr == REG_ADDR) && !sideWrEn;
      prevData <= busWrData[PIX_W-1:0];
    end
  end

  p_window_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    inWindow == (cpuAddr >= 16'h8000 && cpuAddr <= 16'hBFFF));
  p_in_window_map_r2: assert property (@(posedge clk) disable iff (!rstN)
    inWindow |-> (physAddr[OFF_W-1:0] == cpuAddr[OFF_W-1:0] &&
                  physAddr[PHYS_W-1:OFF_W] == sideRdData));
  p_out_window_map_r3: assert property (@(posedge clk) disable iff (!rstN)
    !inWindow |-> (physAddr == PHYS_W'(cpuAddr)));
  p_side_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    sideWrEn |=> (sideRdData == $past(sideWrData)));
  p_bus_late_r4: assert property (@(posedge clk) disable iff (!rstN)
    (prevHit && !sideWrEn) |=> (sideRdData == $past(prevData)));
  p_read_hi_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[REG_W-1:PIX_W] == '0);
  p_read_value_r9: assert property (@(posedge clk) disable iff (!rstN)
    busRdHit ? (busRdData[PIX_W-1:0] == sideRdData) : (busRdData == '0));
endmodule

bind page_window_xlate pwx_checker #(.REG_ADDR(REG_ADDR)) chk_i (
  .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdData(busRdData), .busRdHit(busRdHit),
  .sideWrEn(sideWrEn), .sideWrData(sideWrData), .sideRdData(sideRdData),
  .physAddr(physAddr), .inWindow(inWindow)
);

// File: tb/page_window_xlate_tb_top.sv
`timescale 1ns/1ps
module page_window_xlate_tb_top;
  localparam logic [15:0] REG_A = 16'h0030;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic        busRdHit;
  logic        sideWrEn = 1'b0;
  logic [5:0]  sideWrData = '0;
  logic [5:0]  sideRdData;
  logic [19:0] physAddr;
  logic        inWindow;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  page_window_xlate #(.REG_ADDR(REG_A)) dut_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .busRdHit(busRdHit), .sideWrEn(sideWrEn), .sideWrData(sideWrData),
    .sideRdData(sideRdData), .physAddr(physAddr), .inWindow(inWindow)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic xlate(string req, logic [15:0] a, logic [5:0] pg);
    cpuAddr = a;
    #1;
    if (a >= 16'h8000 && a <= 16'hBFFF) begin
      chk(req, {31'b0, inWindow}, 32'd1);
      chk(req, {12'b0, physAddr}, {12'b0, pg, a[13:0]});
    end else begin
      chk(req, {31'b0, inWindow}, 32'd0);
      chk(req, {12'b0, physAddr}, {16'b0, a});
    end
  endtask

  task automatic readReg(string req, logic [5:0] pg);
    @(negedge clk);
    cpuAddr = REG_A; busRdEn = 1'b1;
    #1;
    chk(req, {31'b0, busRdHit}, 32'd1);
    chk(req, {24'b0, busRdData}, {26'b0, pg});
    busRdEn = 1'b0;
  endtask

  task automatic sideLoad(logic [5:0] v);
    @(negedge clk);
    sideWrEn = 1'b1; sideWrData = v;
    @(negedge clk);
    sideWrEn = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset page", {26'b0, sideRdData}, 32'd0);
    readReg("R1 reset read", 6'd0);
    xlate("R1 reset xlate", 16'h8123, 6'd0);
  endtask

  task automatic t_inWindow();
    sideLoad(6'h2A);
    xlate("R2 base", 16'h8000, 6'h2A);
    xlate("R2 top", 16'hBFFF, 6'h2A);
    xlate("R2 mid", 16'h9234, 6'h2A);
  endtask

  task automatic t_outWindow();
    xlate("R3 below", 16'h7FFF, 6'h2A);
    xlate("R3 above", 16'hC000, 6'h2A);
    xlate("R3 zero", 16'h0000, 6'h2A);
    xlate("R3 max", 16'hFFFF, 6'h2A);
  endtask

  task automatic t_busDelay();
    @(negedge clk);
    cpuAddr = REG_A; busWrEn = 1'b1; busWrData = 8'h15;
    @(negedge clk);
    busWrEn = 1'b0;
    chk("R4 not yet", {26'b0, sideRdData}, 32'h2A);
    @(negedge clk);
    chk("R4 applied R11", {26'b0, sideRdData}, 32'h15);
    xlate("R4 xlate", 16'hA000, 6'h15);
  endtask

  task automatic t_busOther();
    @(negedge clk);
    cpuAddr = REG_A + 16'd1; busWrEn = 1'b1; busWrData = 8'h3F;
    @(negedge clk);
    busWrEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R5 foreign addr", {26'b0, sideRdData}, 32'h15);
  endtask

  task automatic t_side();
    sideLoad(6'h07);
    chk("R6 side immediate", {26'b0, sideRdData}, 32'h07);
    xlate("R6 xlate", 16'h8004, 6'h07);
  endtask

  task automatic t_collide();
    @(negedge clk);
    cpuAddr = REG_A; busWrEn = 1'b1; busWrData = 8'h11;
    sideWrEn = 1'b1; sideWrData = 6'h22;
    @(negedge clk);
    busWrEn = 1'b0; sideWrEn = 1'b0;
    chk("R7 side wins", {26'b0, sideRdData}, 32'h22);
    @(negedge clk);
    @(negedge clk);
    chk("R7 bus discarded", {26'b0, sideRdData}, 32'h22);
  endtask

  task automatic t_pendCancel();
    @(negedge clk);
    cpuAddr = REG_A; busWrEn = 1'b1; busWrData = 8'h0C;
    @(negedge clk);
    busWrEn = 1'b0; sideWrEn = 1'b1; sideWrData = 6'h30;
    @(negedge clk);
    sideWrEn = 1'b0;
    chk("R8 side over pending", {26'b0, sideRdData}, 32'h30);
    @(negedge clk);
    chk("R8 pending dropped", {26'b0, sideRdData}, 32'h30);
  endtask

  task automatic t_read();
    readReg("R9 side-loaded read", 6'h30);
    @(negedge clk);
    cpuAddr = REG_A + 16'd4; busRdEn = 1'b1;
    #1;
    chk("R9 other addr hit", {31'b0, busRdHit}, 32'd0);
    chk("R9 other addr data", {24'b0, busRdData}, 32'd0);
    cpuAddr = REG_A; busRdEn = 1'b0;
    #1;
    chk("R9 no strobe data", {24'b0, busRdData}, 32'd0);
  endtask

  task automatic t_upper();
    @(negedge clk);
    cpuAddr = REG_A; busWrEn = 1'b1; busWrData = 8'hFF;
    @(negedge clk);
    busWrEn = 1'b0;
    @(negedge clk);
    chk("R10 page from low bits", {26'b0, sideRdData}, 32'h3F);
    readReg("R10 upper bits zero", 6'h3F);
    xlate("R10 xlate top page", 16'hBFFF, 6'h3F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_inWindow();
    t_outWindow();
    t_busDelay();
    t_busOther();
    t_side();
    t_collide();
    t_pendCancel();
    t_read();
    t_upper();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule